// File: doc/BRIEF.md
# Multi-Channel Temperature Limit Monitor

This block watches a small set of temperature channels (three by default) on behalf of a host. Each channel delivers signed 8-bit readings in degrees Celsius on a sample port. A host reaches the block through a 16-byte register window. A channel-select register chooses which channel's registers appear in the banked part of the window. For each channel the banked part holds a config/status byte, the latest reading and three signed limits: low, high and over-temperature.

A three-state mode sequencer gates all monitoring. The states are SLEEP, WAKE and RUN. The transitions are:
- SLEEP to WAKE when the host writes 0 to the standby bit.
- WAKE to RUN on the following cycle.
- WAKE or RUN to SLEEP when the host writes 1 to the standby bit.

In RUN, each enabled channel latches each valid sample, compares it with its limits and raises sticky warning flags. The host clears a flag by writing 1 to it. A hardware alarm output is raised while any channel's sticky over-temperature flag is set, and it drops when software clears the last one.

Top module: `tmp_limit_mon`

## Requirements
- R1: After reset the block is in SLEEP (standby bit reads 1), the channel select is 0, every channel is disabled, all warning flags and the alarm are 0, and all readings and limits are 0.
- R2: Offset 0x08 bit 0 is the standby bit. Writing 0 to it in SLEEP moves to WAKE. WAKE moves to RUN on the next cycle. Writing 1 to it in WAKE or RUN moves to SLEEP. The bit reads 1 only in SLEEP, and its other bits read 0.
- R3: Offset 0x09 holds the channel select. A written value below the channel count is stored, and a larger value is ignored. Offsets 0x0A to 0x0E access only the selected channel.
- R4: Offset 0x0B returns the latest sample accepted for the selected channel. A sample is accepted only in RUN, with the channel enabled and its valid bit high. Otherwise the reading holds its value.
- R5: An accepted sample that is less than or equal to the low limit, compared as signed values, sets config bit 1 (low warning).
- R6: An accepted sample that is greater than or equal to the high limit sets config bit 2 (high warning). One that is greater than or equal to the over-temperature limit sets config bit 3 (over-temperature warning). Both comparisons are signed.
- R7: Warning bits are sticky. Writing 1 to a warning bit at 0x0A clears it, and writing 0 has no effect. If a clear and an accepted sample that meets the condition land in the same cycle, the bit stays set.
- R8: Config bit 0 is a read/write channel enable. Bit 6 reads the live open-circuit input of the selected channel. Bits 4, 5 and 7 read 0.
- R9: The alarm output is high exactly when at least one channel's sticky over-temperature flag is set.
- R10: Offsets 0x0C, 0x0D and 0x0E are the selected channel's high, low and over-temperature limits, and they read back as written. Any offset outside 0x08 to 0x0E reads 0, and a write to it changes nothing.
- R11: In SLEEP and in WAKE, and for a disabled channel, no warning flag is newly set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| smp_valid | input | NCH | Per-channel sample valid |
| smp_data | input | 8*NCH | Per-channel signed sample, channel 0 in the low byte |
| smp_open | input | NCH | Per-channel open-circuit indication |
| ot_alarm | output | 1 | Over-temperature alarm |

## Verification
The bench builds the block with its default of three channels and 8-bit data. With three channels the select register's 2-bit field can hold 3, so a write of an out-of-range select can be tried and must be ignored. With 8-bit data the readings and limits cover the whole signed range, so -128 and 127 are reached as limits and as samples. The bench uses a directed sequence for each mode transition and flag rule, then a long random mix of writes, mode changes and samples. A behavioural model predicts the read data and the alarm on every cycle.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
    typedef enum logic [1:0] {
        MODE_SLEEP = 2'd0,
        MODE_WAKE  = 2'd1,
        MODE_RUN   = 2'd2
    } tmon_mode_e;

    localparam logic [3:0] OFS_STBY  = 4'h8;
    localparam logic [3:0] OFS_CHSEL = 4'h9;
    localparam logic [3:0] OFS_CFG   = 4'hA;
    localparam logic [3:0] OFS_READ  = 4'hB;
    localparam logic [3:0] OFS_HI    = 4'hC;
    localparam logic [3:0] OFS_LO    = 4'hD;
    localparam logic [3:0] OFS_OT    = 4'hE;

    localparam int CFG_EN   = 0;
    localparam int CFG_LO   = 1;
    localparam int CFG_HI   = 2;
    localparam int CFG_OT   = 3;
    localparam int CFG_OPEN = 6;
    localparam int NFLAG    = 3;
endpackage

// File: rtl/tmon_mode_fsm.sv
module tmon_mode_fsm
    import tmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_wr,
    input  logic       stby_bit,
    output tmon_mode_e mode,
    output logic       run,
    output logic       standby
);
    tmon_mode_e mode_q, mode_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_SLEEP;
        else        mode_q <= mode_d;
    end

    // transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SLEEP: if (stby_wr && !stby_bit) mode_d = MODE_WAKE;
            MODE_WAKE:  mode_d = (stby_wr && stby_bit) ? MODE_SLEEP : MODE_RUN;
            MODE_RUN:   if (stby_wr && stby_bit) mode_d = MODE_SLEEP;
            default:    mode_d = MODE_SLEEP;
        endcase
    end

    // outputs
    always_comb begin
        mode    = mode_q;
        run     = (mode_q == MODE_RUN);
        standby = (mode_q == MODE_SLEEP);
    end
endmodule

// File: rtl/tmon_chan.sv
module tmon_chan
    import tmon_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sel_hit,
    input  logic          wr,
    input  logic [3:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          smp_open,
    output logic [7:0]    rd_byte,
    output logic [NFLAG-1:0] flags,
    output logic [DW-1:0] reading
);
    logic              en_q;
    logic [NFLAG-1:0]  flg_q, flg_set, flg_clr;
    logic [DW-1:0]     rd_q, hi_q, lo_q, ot_q;
    logic              accept, wr_hit;

    always_comb begin
        wr_hit  = sel_hit && wr;
        accept  = run && en_q && smp_valid;
        flg_clr = (wr_hit && addr == OFS_CFG) ? wdata[CFG_OT:CFG_LO] : '0;
        flg_set = '0;
        if (accept) begin
            flg_set[0] = $signed(smp_data) <= $signed(lo_q);
            flg_set[1] = $signed(smp_data) >= $signed(hi_q);
            flg_set[2] = $signed(smp_data) >= $signed(ot_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            flg_q <= '0;
            rd_q  <= '0;
            hi_q  <= '0;
            lo_q  <= '0;
            ot_q  <= '0;
        end else begin
            flg_q <= (flg_q & ~flg_clr) | flg_set;
            if (accept) rd_q <= smp_data;
            if (wr_hit) begin
                case (addr)
                    OFS_CFG: en_q <= wdata[CFG_EN];
                    OFS_HI:  hi_q <= wdata[DW-1:0];
                    OFS_LO:  lo_q <= wdata[DW-1:0];
                    OFS_OT:  ot_q <= wdata[DW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        case (addr)
            OFS_CFG: begin
                rd_byte[CFG_EN]          = en_q;
                rd_byte[CFG_OT:CFG_LO]   = flg_q;
                rd_byte[CFG_OPEN]        = smp_open;
            end
            OFS_READ: rd_byte = 8'(rd_q);
            OFS_HI:   rd_byte = 8'(hi_q);
            OFS_LO:   rd_byte = 8'(lo_q);
            OFS_OT:   rd_byte = 8'(ot_q);
            default:  rd_byte = '0;
        endcase
        flags   = flg_q;
        reading = rd_q;
    end
endmodule

// File: rtl/tmp_limit_mon.sv
module tmp_limit_mon
    import tmon_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    smp_valid,
    input  logic [NCH*DW-1:0] smp_data,
    input  logic [NCH-1:0]    smp_open,
    output logic              ot_alarm
);
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

    tmon_mode_e             mode;
    logic                   run, standby;
    logic [SELW-1:0]        sel_q;
    logic [7:0]             chan_rd [NCH];
    logic [NCH*NFLAG-1:0]   flag_vec;
    logic [NCH*DW-1:0]      read_vec;
    logic [NCH-1:0]         ot_bits;

    tmon_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stby_wr  (bus_wr && bus_addr == OFS_STBY),
        .stby_bit (bus_wdata[0]),
        .mode     (mode),
        .run      (run),
        .standby  (standby)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (bus_wr && bus_addr == OFS_CHSEL && bus_wdata < 8'(NCH))
            sel_q <= bus_wdata[SELW-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmon_chan #(.DW(DW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .sel_hit   (sel_q == SELW'(i)),
            .wr        (bus_wr),
            .addr      (bus_addr),
            .wdata     (bus_wdata),
            .smp_valid (smp_valid[i]),
            .smp_data  (smp_data[i*DW +: DW]),
            .smp_open  (smp_open[i]),
            .rd_byte   (chan_rd[i]),
            .flags     (flag_vec[i*NFLAG +: NFLAG]),
            .reading   (read_vec[i*DW +: DW])
        );
        assign ot_bits[i] = flag_vec[i*NFLAG + 2];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STBY:  bus_rdata = {7'd0, standby};
            OFS_CHSEL: bus_rdata = 8'(sel_q);
            OFS_CFG, OFS_READ, OFS_HI, OFS_LO, OFS_OT:
                       bus_rdata = chan_rd[sel_q];
            default:   bus_rdata = '0;
        endcase
        ot_alarm = |ot_bits;
    end
endmodule

// File: rtl/tmp_limit_mon_chk.sv
module tmp_limit_mon_chk
    import tmon_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [3:0]           bus_addr,
    input logic [7:0]           bus_wdata,
    input logic                 ot_alarm,
    input tmon_mode_e           mode,
    input logic [NCH*NFLAG-1:0] flag_vec,
    input logic [NCH*DW-1:0]    read_vec
);
    a_r2_wake_then_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WAKE && !(bus_wr && bus_addr == OFS_STBY && bus_wdata[0]))
        |=> mode == MODE_RUN);

    a_r2_sleep_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STBY && bus_wdata[0]) |=> mode == MODE_SLEEP);

    a_r11_no_new_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN) |=> ((flag_vec & ~$past(flag_vec)) == '0));

    a_r4_reading_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_RUN) |=> $stable(read_vec));

    a_r9_alarm_drop_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ot_alarm) |-> $past(bus_wr && bus_addr == OFS_CFG && bus_wdata[CFG_OT]));
endmodule

bind tmp_limit_mon tmp_limit_mon_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ot_alarm  (ot_alarm),
    .mode      (mode),
    .flag_vec  (flag_vec),
    .read_vec  (read_vec)
);

// File: tb/tmp_limit_mon_tb.sv
`timescale 1ns/1ps
module tmp_limit_mon_tb;
    localparam int NCH = 3;
    localparam int DW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_addr = 4'h0;
    logic [7:0]        bus_wdata = 8'h0;
    logic [7:0]        bus_rdata;
    logic [NCH-1:0]    smp_valid = '0;
    logic [NCH*DW-1:0] smp_data = '0;
    logic [NCH-1:0]    smp_open = '0;
    logic              ot_alarm;

    always #2.5 clk = ~clk;

    tmp_limit_mon #(.NCH(NCH), .DW(DW)) u_dut (.*);

    int n_vec = 0, n_bad = 0;
    string cur_tag = "R1";

    // behavioural model
    int m_mode = 0;            // 0 sleep, 1 wake, 2 run
    int m_sel = 0;
    bit m_en [NCH];
    bit [2:0] m_flg [NCH];     // {ot,hi,lo}
    int m_rd [NCH], m_hi [NCH], m_lo [NCH], m_ot [NCH];

    function automatic int sx(input logic [7:0] v);
        return int'($signed(v));
    endfunction

    task automatic model_reset();
        m_mode = 0; m_sel = 0;
        for (int i = 0; i < NCH; i++) begin
            m_en[i] = 0; m_flg[i] = 0; m_rd[i] = 0;
            m_hi[i] = 0; m_lo[i] = 0; m_ot[i] = 0;
        end
    endtask

    task automatic model_step();
        int nmode;
        int nsel;
        if (!rst_n) begin model_reset(); return; end
        nmode = m_mode;
        if (bus_wr && bus_addr == 4'h8) begin
            if (bus_wdata[0]) nmode = (m_mode == 0) ? 0 : 0;
            else nmode = (m_mode == 0) ? 1 : (m_mode == 1 ? 2 : m_mode);
        end else if (m_mode == 1) nmode = 2;
        if (bus_wr && bus_addr == 4'h8 && bus_wdata[0]) nmode = 0;
        nsel = m_sel;
        if (bus_wr && bus_addr == 4'h9 && int'(bus_wdata) < NCH) nsel = int'(bus_wdata);
        for (int i = 0; i < NCH; i++) begin
            bit acc;
            int s;
            bit [2:0] f;
            acc = (m_mode == 2) && m_en[i] && smp_valid[i];
            s = sx(smp_data[i*DW +: DW]);
            f = m_flg[i];
            if (bus_wr && m_sel == i && bus_addr == 4'hA) f = f & ~bus_wdata[3:1];
            if (acc) begin
                if (s <= m_lo[i]) f[0] = 1;
                if (s >= m_hi[i]) f[1] = 1;
                if (s >= m_ot[i]) f[2] = 1;
                m_rd[i] = s;
            end
            m_flg[i] = f;
            if (bus_wr && m_sel == i) begin
                case (bus_addr)
                    4'hA: m_en[i] = bus_wdata[0];
                    4'hC: m_hi[i] = sx(bus_wdata);
                    4'hD: m_lo[i] = sx(bus_wdata);
                    4'hE: m_ot[i] = sx(bus_wdata);
                    default: ;
                endcase
            end
        end
        m_mode = nmode;
        m_sel = nsel;
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [7:0] v;
        v = 0;
        case (a)
            4'h8: v = {7'd0, m_mode == 0};
            4'h9: v = 8'(m_sel);
            4'hA: begin v[0] = m_en[m_sel]; v[3:1] = m_flg[m_sel]; v[6] = smp_open[m_sel]; end
            4'hB: v = 8'(m_rd[m_sel]);
            4'hC: v = 8'(m_hi[m_sel]);
            4'hD: v = 8'(m_lo[m_sel]);
            4'hE: v = 8'(m_ot[m_sel]);
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'h8: return "R2";
            4'h9: return "R3";
            4'hA: return "R5/R6/R7/R8/R11";
            4'hB: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic compare();
        logic [7:0] e;
        bit ea;
        e = exp_rd(bus_addr);
        ea = 0;
        for (int i = 0; i < NCH; i++) ea |= m_flg[i][2];
        n_vec++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s (%s) addr %h: rdata got %h expected %h",
                     cur_tag, tag_of(bus_addr), bus_addr, bus_rdata, e);
        end
        n_vec++;
        if (ot_alarm !== ea) begin
            n_bad++;
            $display("FAIL %s (R9) ot_alarm got %b expected %b", cur_tag, ot_alarm, ea);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    task automatic peek(input logic [3:0] a);
        bus_addr = a;
        cyc();
    endtask

    task automatic sample(input int ch, input logic [7:0] v, input logic [3:0] a);
        smp_valid = '0;
        smp_valid[ch] = 1;
        smp_data[ch*DW +: DW] = v;
        bus_addr = a;
        cyc();
        smp_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on every offset
        cur_tag = "R1";
        for (int a = 0; a < 16; a++) peek(4'(a));

        // R11: sample while asleep raises nothing
        cur_tag = "R11";
        wr(4'hA, 8'h01);
        sample(0, 8'd5, 4'hA);
        peek(4'hB);

        // R2: wake sequence SLEEP -> WAKE -> RUN
        cur_tag = "R2";
        wr(4'h8, 8'h00);
        peek(4'h8);
        peek(4'h8);

        // R3: select channel 1, then an out-of-range select is ignored
        cur_tag = "R3";
        wr(4'h9, 8'h01);
        wr(4'h9, 8'h03);
        peek(4'h9);

        // R10: limits on channel 1
        cur_tag = "R10";
        wr(4'hA, 8'h01);
        wr(4'hD, 8'hF6);   // -10
        wr(4'hC, 8'd40);
        wr(4'hE, 8'd60);
        peek(4'hC); peek(4'hD); peek(4'hE); peek(4'hF); wr(4'hF, 8'hFF); peek(4'h0);

        // R4/R5/R6: in-range, low edge, high, over-temperature
        cur_tag = "R4";
        sample(1, 8'd20, 4'hB);
        peek(4'hA);
        cur_tag = "R5";
        sample(1, 8'hF6, 4'hA);
        peek(4'hA);
        cur_tag = "R6";
        sample(1, 8'd40, 4'hA);
        sample(1, 8'd60, 4'hA);
        peek(4'hA);

        // R7: write 0 no effect, clear vs simultaneous set, plain clear
        cur_tag = "R7";
        wr(4'hA, 8'h01);
        peek(4'hA);
        smp_valid[1] = 1; smp_data[1*DW +: DW] = 8'd70;
        wr(4'hA, 8'h0F);
        smp_valid = '0;
        peek(4'hA);
        wr(4'hA, 8'h0F);
        peek(4'hA);

        // R8: open input, disable
        cur_tag = "R8";
        smp_open = 3'b010;
        peek(4'hA);
        smp_open = '0;
        wr(4'hA, 8'hF0);
        sample(1, 8'd90, 4'hA);
        peek(4'hB);

        // R9: alarm from channel 2 with extreme limits
        cur_tag = "R9";
        wr(4'h9, 8'h02);
        wr(4'hA, 8'h01);
        wr(4'hE, 8'h7F);
        wr(4'hD, 8'h80);
        sample(2, 8'h7F, 4'hA);
        sample(2, 8'h80, 4'hA);
        wr(4'hA, 8'h09);
        peek(4'hA);

        // R2: back to sleep, samples ignored
        cur_tag = "R2";
        wr(4'h8, 8'h01);
        sample(2, 8'h7F, 4'hA);
        peek(4'h8);

        // random mix across all requirements
        cur_tag = "R2/R3/R4/R5/R6/R7/R10/R11";
        for (int k = 0; k < 6000; k++) begin
            int r;
            r = int'($urandom % 16);
            smp_valid = 3'($urandom);
            smp_data  = 24'($urandom);
            smp_open  = 3'($urandom);
            if (r < 4) begin
                bus_wr = 1;
                if ($urandom % 12 == 0) begin
                    bus_addr = 4'h8;
                    bus_wdata = ($urandom % 4 == 0) ? 8'h01 : 8'h00;
                end else begin
                    bus_addr = 4'(9 + $urandom % 7);
                    bus_wdata = 8'($urandom);
                    if (bus_addr == 4'h9) bus_wdata = 8'($urandom % 4);
                    if (bus_addr == 4'hA && ($urandom % 4 != 0)) bus_wdata[0] = 1;
                end
            end else begin
                bus_wr = 0;
                bus_addr = 4'($urandom);
            end
            cyc();
        end
        bus_wr = 0; smp_valid = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule